// File: doc/BRIEF.md
# Serial Flash Pass-Through Router

This block connects an external SPI host straight through to one of several serial flash devices. It does this once a command decoder elsewhere has recognised a pass-through command. In normal operation the host's serial output comes from the register responder. When the decoder raises a one-cycle request together with a target index, the block takes over. It asserts the processor reset request and pulls the chosen flash's chip select low. From then on the host clock, host data-in and the flash's data-out are wired through combinationally. Only single-bit 4-wire SPI is carried. The block stays in this mode until the host chip select goes high.

When the host chip select rises, the chosen flash's chip select follows it at once, with no clock involved. The controller sees the same rise through a reset-safe synchronizer and leaves the routing state. It then keeps the processor reset request asserted for a set number of clock cycles before it lets go. Flashes that were not chosen always keep their chip select high and their clock and data inputs low. Target 0 is the primary flash and target 1 the secondary one.

Top module: `flash_passthru`

## Requirements
- R1: After reset, `cpu_rst` is low, every bit of `flash_csb` is high, `flash_clk` and `flash_io0` are all zero, and `host_sdo`/`host_sdo_oe` equal `resp_sdo`/`resp_sdo_oe`.
- R2: A request is accepted on a clock edge where `pt_req` is high, the block is idle and the synchronized host chip select is low. From the next clock cycle, `cpu_rst` is high and bit `pt_tgt` of `flash_csb` is low while `host_csb` is low.
- R3: While routing to target t with `host_csb` low, `flash_clk[t]` equals `host_sck` and `flash_io0[t]` equals `host_sdi` in the same cycle, with no clock delay.
- R4: While routing to target t, `host_sdo` equals `flash_io1[t]` and `host_sdo_oe` equals the inverse of `host_csb`.
- R5: Any flash other than the routed one holds `flash_csb` high and `flash_clk` and `flash_io0` low, so at most one chip select is low at any time.
- R6: While routing, `flash_csb[t]` goes high in the same cycle that `host_csb` goes high, and `flash_clk[t]` and `flash_io0[t]` are forced low.
- R7: Routing ends on the clock edge at which the host chip select, after passing through SYNC_STAGES flip-flops, is seen high.
- R8: After routing ends, `cpu_rst` stays high for exactly RST_HOLD clock cycles and then goes low.
- R9: Outside the routing state, `host_sdo` and `host_sdo_oe` follow `resp_sdo` and `resp_sdo_oe`.
- R10: A request is ignored if it arrives while routing, while the reset is being held, or while the synchronized host chip select is high. Routing continues to the target chosen first.
- R11: The target index chooses the bit position in the flash vectors: `pt_tgt`=0 drives bit 0 (primary), `pt_tgt`=1 drives bit 1 (secondary).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_csb | input | 1 | Host chip select, active low |
| host_sck | input | 1 | Host serial clock |
| host_sdi | input | 1 | Host serial data toward the block |
| pt_req | input | 1 | One-cycle pass-through request from the command decoder |
| pt_tgt | input | TGT_W | Target flash index for the request |
| resp_sdo | input | 1 | Serial output from the register responder |
| resp_sdo_oe | input | 1 | Output enable from the register responder |
| flash_io1 | input | NUM_TGT | Data output of each flash |
| flash_csb | output | NUM_TGT | Chip select of each flash, active low |
| flash_clk | output | NUM_TGT | Clock of each flash |
| flash_io0 | output | NUM_TGT | Data input of each flash |
| host_sdo | output | 1 | Serial data toward the host |
| host_sdo_oe | output | 1 | Output enable for host_sdo |
| cpu_rst | output | 1 | Processor reset request |

## Verification
On every cycle the assertions check four things: that no more than one chip select is low, that every flash is quiet while the reset request is low, that the chosen target does not change while routing, and that a request accepted in idle raises the reset. They also check that the reset is released exactly RST_HOLD cycles after routing ends, and that routing stops once the synchronized chip select has been seen high. Other behaviours can only be shown by the bench's scenarios. These include the combinational path of clock, data and SDO with no delay, the chip select rising in the same cycle as the host's, and requests being dropped in each non-idle state. The bench also covers the host chip select dropping again while the reset is held, and the switch between the two targets across separate sessions.

// File: rtl/fpt_pkg.sv
package fpt_pkg;

    typedef enum logic [1:0] {
        PT_IDLE    = 2'd0,
        PT_ACTIVE  = 2'd1,
        PT_RELEASE = 2'd2
    } pt_state_e;

endpackage

// File: rtl/fpt_sync.sv
module fpt_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/fpt_ctrl.sv
module fpt_ctrl
    import fpt_pkg::*;
#(
    parameter int NUM_TGT  = 2,
    parameter int TGT_W    = 1,
    parameter int RST_HOLD = 4,
    parameter int CNT_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csb_sync,
    input  logic             req,
    input  logic [TGT_W-1:0] tgt,
    output logic             route_en,
    output logic [TGT_W-1:0] route_sel,
    output logic             cpu_rst
);

    typedef struct packed {
        pt_state_e        state;
        logic [TGT_W-1:0] sel;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;
    logic  tgt_ok;

    always_comb tgt_ok = (int'(tgt) < NUM_TGT);

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.state)
            PT_IDLE: begin
                if (req && !csb_sync && tgt_ok) begin
                    nxt_d.state = PT_ACTIVE;
                    nxt_d.sel   = tgt;
                end
            end
            PT_ACTIVE: begin
                if (csb_sync) begin
                    nxt_d.state = PT_RELEASE;
                    nxt_d.cnt   = '0;
                end
            end
            PT_RELEASE: begin
                if (cur_q.cnt == CNT_W'(RST_HOLD - 1)) begin
                    nxt_d.state = PT_IDLE;
                    nxt_d.cnt   = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            default: nxt_d.state = PT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state <= PT_IDLE;
            cur_q.sel   <= '0;
            cur_q.cnt   <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign route_en  = (cur_q.state == PT_ACTIVE);
    assign route_sel = cur_q.sel;
    assign cpu_rst   = (cur_q.state != PT_IDLE);

    // Cycle counter used only by the release-window assertion
    int rel_cycles_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    rel_cycles_q <= 0;
        else if (cpu_rst && !route_en) rel_cycles_q <= rel_cycles_q + 1;
        else                           rel_cycles_q <= 0;
    end

    p_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rst && req && !csb_sync && tgt_ok) |=> (route_en && cpu_rst && route_sel == $past(tgt)));

    p_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (route_en && csb_sync) |=> (!route_en && cpu_rst));

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_rst) |-> (rel_cycles_q == RST_HOLD));

    p_sel_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (route_en && $past(route_en)) |-> $stable(route_sel));

endmodule

// File: rtl/fpt_route.sv
module fpt_route #(
    parameter int NUM_TGT = 2,
    parameter int TGT_W   = 1
) (
    input  logic               route_en,
    input  logic [TGT_W-1:0]   route_sel,
    input  logic               host_csb,
    input  logic               host_sck,
    input  logic               host_sdi,
    input  logic               resp_sdo,
    input  logic               resp_sdo_oe,
    input  logic [NUM_TGT-1:0] flash_io1,
    output logic [NUM_TGT-1:0] flash_csb,
    output logic [NUM_TGT-1:0] flash_clk,
    output logic [NUM_TGT-1:0] flash_io0,
    output logic               host_sdo,
    output logic               host_sdo_oe
);

    logic [NUM_TGT-1:0] hit;

    generate
        for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
            always_comb begin
                hit[t]       = route_en && (int'(route_sel) == t);
                flash_csb[t] = !hit[t] || host_csb;
                flash_clk[t] = hit[t] && !host_csb && host_sck;
                flash_io0[t] = hit[t] && !host_csb && host_sdi;
            end
        end
    endgenerate

    always_comb begin
        if (route_en) begin
            host_sdo    = flash_io1[route_sel];
            host_sdo_oe = !host_csb;
        end else begin
            host_sdo    = resp_sdo;
            host_sdo_oe = resp_sdo_oe;
        end
    end

endmodule

// File: rtl/flash_passthru.sv
module flash_passthru #(
    parameter int NUM_TGT     = 2,
    parameter int SYNC_STAGES = 2,
    parameter int RST_HOLD    = 4,
    localparam int TGT_W      = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1,
    localparam int CNT_W      = $clog2(RST_HOLD + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_csb,
    input  logic               host_sck,
    input  logic               host_sdi,
    input  logic               pt_req,
    input  logic [TGT_W-1:0]   pt_tgt,
    input  logic               resp_sdo,
    input  logic               resp_sdo_oe,
    input  logic [NUM_TGT-1:0] flash_io1,
    output logic [NUM_TGT-1:0] flash_csb,
    output logic [NUM_TGT-1:0] flash_clk,
    output logic [NUM_TGT-1:0] flash_io0,
    output logic               host_sdo,
    output logic               host_sdo_oe,
    output logic               cpu_rst
);

    logic             csb_sync;
    logic             route_en;
    logic [TGT_W-1:0] route_sel;

    fpt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (host_csb),
        .q     (csb_sync)
    );

    fpt_ctrl #(
        .NUM_TGT  (NUM_TGT),
        .TGT_W    (TGT_W),
        .RST_HOLD (RST_HOLD),
        .CNT_W    (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .csb_sync  (csb_sync),
        .req       (pt_req),
        .tgt       (pt_tgt),
        .route_en  (route_en),
        .route_sel (route_sel),
        .cpu_rst   (cpu_rst)
    );

    fpt_route #(.NUM_TGT(NUM_TGT), .TGT_W(TGT_W)) u_route (
        .route_en    (route_en),
        .route_sel   (route_sel),
        .host_csb    (host_csb),
        .host_sck    (host_sck),
        .host_sdi    (host_sdi),
        .resp_sdo    (resp_sdo),
        .resp_sdo_oe (resp_sdo_oe),
        .flash_io1   (flash_io1),
        .flash_csb   (flash_csb),
        .flash_clk   (flash_clk),
        .flash_io0   (flash_io0),
        .host_sdo    (host_sdo),
        .host_sdo_oe (host_sdo_oe)
    );

    p_one_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~flash_csb) <= 1);

    p_quiet_when_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rst |-> (&flash_csb && flash_clk == '0 && flash_io0 == '0));

endmodule

// File: tb/flash_passthru_test.sv
module flash_passthru_test;

    localparam int NT   = 2;
    localparam int SYNC = 2;
    localparam int HOLD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_csb = 1'b1, host_sck = 1'b0, host_sdi = 1'b0;
    logic pt_req = 1'b0;
    logic [0:0] pt_tgt = '0;
    logic resp_sdo = 1'b0, resp_sdo_oe = 1'b0;
    logic [NT-1:0] flash_io1 = '0;
    logic [NT-1:0] flash_csb, flash_clk, flash_io0;
    logic host_sdo, host_sdo_oe, cpu_rst;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    flash_passthru #(.NUM_TGT(NT), .SYNC_STAGES(SYNC), .RST_HOLD(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .host_csb(host_csb), .host_sck(host_sck),
        .host_sdi(host_sdi), .pt_req(pt_req), .pt_tgt(pt_tgt),
        .resp_sdo(resp_sdo), .resp_sdo_oe(resp_sdo_oe), .flash_io1(flash_io1),
        .flash_csb(flash_csb), .flash_clk(flash_clk), .flash_io0(flash_io0),
        .host_sdo(host_sdo), .host_sdo_oe(host_sdo_oe), .cpu_rst(cpu_rst)
    );

    // Reference model: 0 idle, 1 routing, 2 holding reset
    int m_st = 0, m_sel = 0, m_cnt = 0;
    int csb_pipe[$];

    always @(posedge clk) begin
        int seen;
        if (!rst_n) begin
            m_st = 0; m_sel = 0; m_cnt = 0;
            csb_pipe = {};
            for (int i = 0; i < SYNC; i++) csb_pipe.push_back(1);
        end else begin
            seen = csb_pipe[0];
            case (m_st)
                0: if (pt_req && seen == 0) begin m_st = 1; m_sel = int'(pt_tgt); end
                1: if (seen == 1) begin m_st = 2; m_cnt = 0; end
                default: begin
                    m_cnt++;
                    if (m_cnt == HOLD) begin m_st = 0; m_cnt = 0; end
                end
            endcase
            void'(csb_pipe.pop_front());
            csb_pipe.push_back(int'(host_csb));
        end
    end

    task automatic chk(string req, string what, logic [3:0] got, logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, got, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the clock edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [NT-1:0] e_csb, e_clk, e_io0;
            logic e_sdo, e_oe;
            for (int t = 0; t < NT; t++) begin
                bit hit;
                hit      = (m_st == 1) && (m_sel == t);
                e_csb[t] = !hit || host_csb;
                e_clk[t] = hit && !host_csb && host_sck;
                e_io0[t] = hit && !host_csb && host_sdi;
            end
            e_sdo = (m_st == 1) ? flash_io1[m_sel] : resp_sdo;
            e_oe  = (m_st == 1) ? !host_csb : resp_sdo_oe;
            chk((m_st == 1) ? (host_csb ? "R6" : "R5") : "R1", "flash_csb", 4'(flash_csb), 4'(e_csb));
            chk((m_st == 1) ? "R3" : "R7", "flash_clk", 4'(flash_clk), 4'(e_clk));
            chk((m_st == 1) ? "R3" : "R7", "flash_io0", 4'(flash_io0), 4'(e_io0));
            chk((m_st == 1) ? "R4" : "R9", "host_sdo", 4'(host_sdo), 4'(e_sdo));
            chk((m_st == 1) ? "R4" : "R9", "host_sdo_oe", 4'(host_sdo_oe), 4'(e_oe));
            chk((m_st == 1) ? "R2" : "R8", "cpu_rst", 4'(cpu_rst), 4'(m_st != 0));
        end
    end

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic at_sample();
        @(negedge clk);
    endtask

    task automatic request(int t);
        pt_tgt = 1'(t); pt_req = 1'b1;
        step();
        pt_req = 1'b0;
    endtask

    task automatic wiggle(int n, int seed);
        for (int i = 0; i < n; i++) begin
            host_sck  = ~host_sck;
            host_sdi  = 1'((seed >> (i % 7)) & 1);
            flash_io1 = NT'((seed + i * 3) >> 1);
            resp_sdo  = 1'(i & 1);
            step();
        end
        host_sck = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        at_sample();
        // R1: reset state
        chk("R1", "cpu_rst after reset", 4'(cpu_rst), 4'h0);
        chk("R1", "flash_csb after reset", 4'(flash_csb), 4'h3);
        step();

        // R9: responder owns SDO while idle
        resp_sdo_oe = 1'b1;
        wiggle(6, 8'h5a);

        // Session on primary target (R11)
        host_csb = 1'b0;
        step(SYNC + 1);
        request(0);
        at_sample();
        chk("R2", "cpu_rst on entry", 4'(cpu_rst), 4'h1);
        chk("R11", "target 0 selects bit 0", 4'(flash_csb), 4'h2);
        step();
        wiggle(12, 8'hc3);
        // R10: second request while routing is dropped
        request(1);
        at_sample();
        chk("R10", "request while routing", 4'(flash_csb), 4'h2);
        step();
        wiggle(4, 8'h96);
        host_csb = 1'b1;
        at_sample();
        chk("R6", "csb follows host immediately", 4'(flash_csb), 4'h3);
        step();
        // R10: request during reset hold is dropped
        step(SYNC);
        host_csb = 1'b0;
        request(1);
        at_sample();
        chk("R10", "request while holding reset", 4'(flash_csb), 4'h3);
        step(HOLD + SYNC + 2);
        at_sample();
        chk("R8", "reset released after hold", 4'(cpu_rst), 4'h0);

        // R10: request while synchronized csb high
        host_csb = 1'b1;
        step(SYNC + 1);
        request(1);
        at_sample();
        chk("R10", "request while csb high", 4'(cpu_rst), 4'h0);
        step();

        // Session on secondary target (R11)
        host_csb = 1'b0;
        step(SYNC + 1);
        request(1);
        at_sample();
        chk("R11", "target 1 selects bit 1", 4'(flash_csb), 4'h1);
        step();
        wiggle(16, 8'h3c);
        host_csb = 1'b1;
        step();
        wiggle(3, 8'h11);
        at_sample();
        chk("R7", "routing stopped after sync", 4'(flash_clk), 4'h0);
        step(HOLD + 4);
        wiggle(4, 8'h77);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule